// File: doc/BRIEF.md
# Interrupt-Triggered Descriptor Transfer Engine

This block moves a single byte or word each time an enabled peripheral interrupt is raised. It keeps no per-channel state in registers. For the vector number it is serving, it reads a pointer from a table in memory. The pointer locates a four-word descriptor holding the mode, the source address, the destination address and the remaining count. The engine moves the data, writes back the addresses it has advanced and the decremented count, and tells the peripheral to drop its interrupt flag. When the count reaches zero, it passes the same vector number on to the CPU as an interrupt.

Software controls a per-vector transfer-enable register. A changed enable setting is not seen by request qualification until priority resolution has had two clocks to settle. Enable bits for vectors that are not wired to the engine are held at zero. Requests that arrive while a transfer is running are kept pending. Once the engine is idle again, they are served lowest vector number first. The memory side is one master port that holds its request until the memory returns ready. The data width must be at least the address width.

Top module: `irq_xfer_engine`

## Requirements
- R1: For vector v the first access of a transfer is a word read at `TBL_BASE + 2*v`, and the value read is the descriptor address P. The descriptor consists of mode at P, source at P+2, destination at P+4 and count at P+6. Mode bit 0 selects word size (1) or byte size (0), bit 1 enables source advance, and bit 2 enables destination advance.
- R2: One data item is read from the source and written to the destination. A byte item travels on bits 7:0 of the data bus, and a byte write changes only the addressed byte.
- R3: When mode bit 1 is set, the source slot P+2 is rewritten with the source address plus 1 (byte) or plus 2 (word). Otherwise that slot is left unchanged.
- R4: When mode bit 2 is set, the destination slot P+4 is rewritten in the same way. Otherwise that slot is left unchanged.
- R5: The count slot P+6 is rewritten with the count minus one on every transfer.
- R6: When the rewritten count is zero, `cpu_irq` pulses high for one cycle with `cpu_vec` = v, after the engine has left the busy state. No pulse occurs for a nonzero count.
- R7: Each served request produces exactly one one-cycle `flag_clr` pulse with `flag_id` = v.
- R8: The engine never modifies the enable register. `en_q` returns the last written value ANDed with the assigned-vector mask, before and after transfers.
- R9: A written enable value qualifies requests from the third clock edge after the write edge. With a request already waiting and the engine idle, `busy` is low after write edges +1 to +3 and high after edge +4. A request whose enable bit is clear is not served.
- R10: Enable bits of vectors outside the assigned mask (default 8'hB7) read as zero. A request on such a vector causes no memory access, no `busy` and no `flag_clr`.
- R11: Requests raised while busy are held and served after the current transfer, lowest vector number first.
- R12: `busy` is high from the table read until the count write-back completes, and `mem_req` is high only while busy. A stalled access holds its address and direction until `mem_ready`.
- R13: After reset, `busy`, `mem_req`, `cpu_irq`, `flag_clr` and `en_q` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NVEC | Peripheral interrupt flags, one per vector |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | NVEC | New enable value |
| en_q | output | NVEC | Enable register read-back |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_word | output | 1 | Access size: 1 word, 0 byte |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Access completes on this edge |
| flag_clr | output | 1 | Clear strobe to the requesting peripheral |
| flag_id | output | VW | Vector whose flag is cleared |
| busy | output | 1 | Transfer in progress |
| cpu_irq | output | 1 | Completion interrupt pulse to the CPU |
| cpu_vec | output | VW | Vector of the completed transfer |

## Verification
The hardest situation to reach is the moment an enable write lands while a request is already waiting. Catching the exact edge at which the engine starts needs a request held on a disabled vector, memory stalls switched off, and the enable written from an idle engine with `busy` sampled after each following edge. Queue ordering is reached by raising one vector, waiting for `busy`, and then raising a higher and a lower vector together. Randomised rounds combine stalled memory, random modes and counts, and several vectors raised at once in disjoint memory regions, so the end state of memory does not depend on service order.

// File: rtl/ixe_pkg.sv
package ixe_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_VEC, S_MODE, S_SRC, S_RDAT, S_SWB,
    S_DST, S_WDAT, S_DWB, S_CNT, S_CWB
  } ixe_state_e;

  localparam int MODE_WORD = 0;
  localparam int MODE_SINC = 1;
  localparam int MODE_DINC = 2;
  localparam int MODE_BITS = 3;
endpackage

// File: rtl/ixe_enable.sv
module ixe_enable #(
  parameter int NVEC = 8,
  parameter logic [NVEC-1:0] ASSIGNED = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [NVEC-1:0] wdata,
  output logic [NVEC-1:0] en_q,
  output logic [NVEC-1:0] en_eff
);
  logic [NVEC-1:0] en_d1;

  // software-visible copy, only unassigned bits forced low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= wdata & ASSIGNED;
  end

  // two settling stages for priority resolution
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d1  <= '0;
      en_eff <= '0;
    end else begin
      en_d1  <= en_q;
      en_eff <= en_d1;
    end
  end
endmodule

// File: rtl/ixe_pending.sv
module ixe_pending #(
  parameter int NVEC = 8,
  localparam int VW = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] req,
  input  logic [NVEC-1:0] en_eff,
  input  logic            take,
  input  logic            flag_clr,
  input  logic [VW-1:0]   clr_id,
  output logic            pend_any,
  output logic [VW-1:0]   pick_id
);
  logic [NVEC-1:0] pend_q, pend_d, take_oh, clr_oh;
  logic            found;

  always_comb begin
    take_oh = take     ? (NVEC'(1) << pick_id) : '0;
    clr_oh  = flag_clr ? (NVEC'(1) << clr_id)  : '0;
    // flag still high while its clear is in flight: do not re-arm
    pend_d  = (pend_q | (req & en_eff & ~clr_oh & ~take_oh)) & ~take_oh;
  end

  always_comb begin
    pick_id = '0;
    found   = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      if (pend_q[i] && !found) begin
        pick_id = VW'(i);
        found   = 1'b1;
      end
    end
    pend_any = |pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/ixe_seq.sv
module ixe_seq
  import ixe_pkg::*;
#(
  parameter int NVEC = 8,
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] TBL_BASE = '0,
  localparam int VW = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_any,
  input  logic [VW-1:0] pick_id,
  output logic          take,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_word,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          flag_clr,
  output logic [VW-1:0] clr_id,
  output logic          cpu_irq,
  output logic [VW-1:0] cpu_vec
);
  ixe_state_e           state_q, state_d;
  logic [VW-1:0]        vec_q;
  logic [AW-1:0]        ptr_q, src_q, dst_q, step_inc;
  logic [MODE_BITS-1:0] mode_q;
  logic [DW-1:0]        data_q, cnt_q, cnt_dec;
  logic                 step, done_zero;

  assign step      = (state_q != S_IDLE) && mem_ready;
  assign step_inc  = mode_q[MODE_WORD] ? AW'(2) : AW'(1);
  assign cnt_dec   = cnt_q - DW'(1);
  assign done_zero = step && (state_q == S_CWB) && (cnt_dec == '0);
  assign take      = (state_q == S_IDLE) && pend_any;
  assign busy      = (state_q != S_IDLE);

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (pend_any) state_d = S_VEC;
      S_VEC:  if (mem_ready) state_d = S_MODE;
      S_MODE: if (mem_ready) state_d = S_SRC;
      S_SRC:  if (mem_ready) state_d = S_RDAT;
      S_RDAT: if (mem_ready) state_d = mode_q[MODE_SINC] ? S_SWB : S_DST;
      S_SWB:  if (mem_ready) state_d = S_DST;
      S_DST:  if (mem_ready) state_d = S_WDAT;
      S_WDAT: if (mem_ready) state_d = mode_q[MODE_DINC] ? S_DWB : S_CNT;
      S_DWB:  if (mem_ready) state_d = S_CNT;
      S_CNT:  if (mem_ready) state_d = S_CWB;
      S_CWB:  if (mem_ready) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // memory access decode
  always_comb begin
    mem_req   = busy;
    mem_we    = 1'b0;
    mem_word  = 1'b1;
    mem_addr  = ptr_q;
    mem_wdata = '0;
    case (state_q)
      S_VEC:  mem_addr = TBL_BASE + AW'({vec_q, 1'b0});
      S_SRC:  mem_addr = ptr_q + AW'(2);
      S_RDAT: begin mem_addr = src_q; mem_word = mode_q[MODE_WORD]; end
      S_SWB:  begin mem_addr = ptr_q + AW'(2); mem_we = 1'b1;
                    mem_wdata = DW'(src_q + step_inc); end
      S_DST:  mem_addr = ptr_q + AW'(4);
      S_WDAT: begin mem_addr = dst_q; mem_word = mode_q[MODE_WORD]; mem_we = 1'b1;
                    mem_wdata = data_q; end
      S_DWB:  begin mem_addr = ptr_q + AW'(4); mem_we = 1'b1;
                    mem_wdata = DW'(dst_q + step_inc); end
      S_CNT:  mem_addr = ptr_q + AW'(6);
      S_CWB:  begin mem_addr = ptr_q + AW'(6); mem_we = 1'b1; mem_wdata = cnt_dec; end
      default: ;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      flag_clr <= 1'b0;
      clr_id   <= '0;
      cpu_irq  <= 1'b0;
      cpu_vec  <= '0;
    end else begin
      state_q  <= state_d;
      flag_clr <= take;
      if (take)      clr_id  <= pick_id;
      cpu_irq  <= done_zero;
      if (done_zero) cpu_vec <= vec_q;
    end
  end

  // datapath registers, loaded by explicit enables
  always_ff @(posedge clk) begin
    if (take)                     vec_q  <= pick_id;
    if (step && state_q == S_VEC)  ptr_q  <= mem_rdata[AW-1:0];
    if (step && state_q == S_MODE) mode_q <= mem_rdata[MODE_BITS-1:0];
    if (step && state_q == S_SRC)  src_q  <= mem_rdata[AW-1:0];
    if (step && state_q == S_RDAT) data_q <= mode_q[MODE_WORD] ? mem_rdata
                                             : {{(DW-8){1'b0}}, mem_rdata[7:0]};
    if (step && state_q == S_DST)  dst_q  <= mem_rdata[AW-1:0];
    if (step && state_q == S_CNT)  cnt_q  <= mem_rdata;
  end
endmodule

// File: rtl/irq_xfer_engine.sv
module irq_xfer_engine #(
  parameter int NVEC = 8,
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0]   TBL_BASE = 16'h0040,
  parameter logic [NVEC-1:0] ASSIGNED = 8'hB7,
  localparam int VW = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] irq_req,
  input  logic            en_wr,
  input  logic [NVEC-1:0] en_wdata,
  output logic [NVEC-1:0] en_q,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_word,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready,
  output logic            flag_clr,
  output logic [VW-1:0]   flag_id,
  output logic            busy,
  output logic            cpu_irq,
  output logic [VW-1:0]   cpu_vec
);
  logic [NVEC-1:0] en_eff;
  logic            pend_any, take;
  logic [VW-1:0]   pick_id;

  ixe_enable #(.NVEC(NVEC), .ASSIGNED(ASSIGNED)) u_enable (
    .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata),
    .en_q(en_q), .en_eff(en_eff)
  );

  ixe_pending #(.NVEC(NVEC)) u_pending (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .en_eff(en_eff),
    .take(take), .flag_clr(flag_clr), .clr_id(flag_id),
    .pend_any(pend_any), .pick_id(pick_id)
  );

  ixe_seq #(.NVEC(NVEC), .AW(AW), .DW(DW), .TBL_BASE(TBL_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .pend_any(pend_any), .pick_id(pick_id),
    .take(take), .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .busy(busy), .flag_clr(flag_clr), .clr_id(flag_id),
    .cpu_irq(cpu_irq), .cpu_vec(cpu_vec)
  );
endmodule

// File: rtl/ixe_chk.sv
module ixe_chk #(
  parameter int NVEC = 8,
  parameter int AW = 16,
  parameter logic [NVEC-1:0] ASSIGNED = '1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NVEC-1:0] en_q,
  input logic [NVEC-1:0] en_eff,
  input logic            mem_req,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_ready,
  input logic            flag_clr,
  input logic            busy,
  input logic            cpu_irq
);
  AST_EN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_eff == $past(en_q, 2)); // R9
  AST_UNASSIGNED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en_eff & ~ASSIGNED) == '0); // R10
  AST_FIRST_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !mem_we); // R1
  AST_LAST_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_we)); // R5
  AST_IRQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> !busy); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |=> !cpu_irq); // R6
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !flag_clr); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
endmodule

bind irq_xfer_engine ixe_chk #(.NVEC(NVEC), .AW(AW), .ASSIGNED(ASSIGNED)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_eff(en_eff),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready),
  .flag_clr(flag_clr), .busy(busy), .cpu_irq(cpu_irq)
);

// File: tb/tb_irq_xfer_engine.sv
module tb_irq_xfer_engine;
  localparam int N = 8;
  localparam int VW = 3;
  localparam logic [15:0] TBL  = 16'h0040;
  localparam logic [15:0] DESC = 16'h0100;
  localparam logic [7:0]  ASG  = 8'hB7;

  logic clk, rst_n, en_wr, mem_req, mem_we, mem_word, mem_ready, flag_clr, busy, cpu_irq;
  logic [N-1:0] irq_req, en_wdata, en_q, raise, flag;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [VW-1:0] flag_id, cpu_vec;

  logic [7:0] mem [0:4095];
  logic [7:0] exp_m [0:4095];
  logic hw_en, stall;
  logic [11:0] hw_addr;
  logic [7:0] hw_data;
  int clr_log [0:255];
  int clr_n, busy_cyc;
  int irq_cnt [0:N-1];
  int exp_irq [0:N-1];
  int nchk, nerr;

  irq_xfer_engine dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .en_wr(en_wr), .en_wdata(en_wdata),
    .en_q(en_q), .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .flag_clr(flag_clr), .flag_id(flag_id), .busy(busy),
    .cpu_irq(cpu_irq), .cpu_vec(cpu_vec)
  );

  always #10 clk = ~clk;

  assign irq_req = flag;
  assign mem_rdata = mem_word ? {mem[12'(mem_addr[11:0] + 12'd1)], mem[mem_addr[11:0]]}
                              : {8'h00, mem[mem_addr[11:0]]};

  // memory model, peripheral flags and event logs
  always @(posedge clk) begin
    if (hw_en) mem[hw_addr] <= hw_data;
    else if (mem_req && mem_we && mem_ready) begin
      mem[mem_addr[11:0]] <= mem_wdata[7:0];
      if (mem_word) mem[12'(mem_addr[11:0] + 12'd1)] <= mem_wdata[15:8];
    end
    if (!rst_n) begin
      flag <= '0; clr_n <= 0; busy_cyc <= 0;
      for (int i = 0; i < N; i++) irq_cnt[i] <= 0;
    end else begin
      flag <= (flag | raise) & ~(flag_clr ? (N'(1) << flag_id) : '0);
      if (flag_clr) begin clr_log[clr_n[7:0]] <= int'(flag_id); clr_n <= clr_n + 1; end
      if (cpu_irq) irq_cnt[cpu_vec] <= irq_cnt[cpu_vec] + 1;
      if (busy) busy_cyc <= busy_cyc + 1;
    end
  end

  always @(negedge clk) mem_ready <= stall ? (($urandom % 3) != 0) : 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_addr = a; hw_data = d; exp_m[a] = d;
    @(posedge clk);
    #1 hw_en = 1'b0;
  endtask

  task automatic poke16(input logic [15:0] a, input logic [15:0] d);
    poke(a[11:0], d[7:0]);
    poke(12'(a[11:0] + 12'd1), d[15:8]);
  endtask

  function automatic logic [15:0] rd16(input logic [15:0] a);
    return {exp_m[12'(a[11:0] + 12'd1)], exp_m[a[11:0]]};
  endfunction

  task automatic wr16(input logic [15:0] a, input logic [15:0] d);
    exp_m[a[11:0]] = d[7:0];
    exp_m[12'(a[11:0] + 12'd1)] = d[15:8];
  endtask

  task automatic setup(input int v, input logic [2:0] mode, input logic [15:0] src,
                       input logic [15:0] dst, input logic [15:0] cnt);
    logic [15:0] p;
    p = DESC + 16'(16 * v);
    poke16(TBL + 16'(2 * v), p);
    poke16(p, {13'd0, mode});
    poke16(p + 16'd2, src);
    poke16(p + 16'd4, dst);
    poke16(p + 16'd6, cnt);
    for (int k = 0; k < 8; k++) poke(12'(src[11:0] + 12'(k)), 8'($urandom));
  endtask

  // reference transfer computed from the requirements
  task automatic model_xfer(input int v);
    logic [15:0] p, mode, s, d, c, inc;
    p = rd16(TBL + 16'(2 * v));
    mode = rd16(p); s = rd16(p + 16'd2); d = rd16(p + 16'd4); c = rd16(p + 16'd6);
    inc = mode[0] ? 16'd2 : 16'd1;
    exp_m[d[11:0]] = exp_m[s[11:0]];
    if (mode[0]) exp_m[12'(d[11:0] + 12'd1)] = exp_m[12'(s[11:0] + 12'd1)];
    if (mode[1]) wr16(p + 16'd2, s + inc);
    if (mode[2]) wr16(p + 16'd4, d + inc);
    wr16(p + 16'd6, c - 16'd1);
    if (c == 16'd1) exp_irq[v]++;
  endtask

  task automatic compare_mem(input string tag);
    int bad, first;
    bad = 0; first = 0;
    for (int a = 0; a < 4096; a++)
      if (mem[a] !== exp_m[a]) begin
        if (bad == 0) first = a;
        bad++;
      end
    if (bad != 0)
      check(1'b0, $sformatf("%s mem[%0h]", tag, first), int'(mem[first]), int'(exp_m[first]));
    else check(1'b1, tag, 0, 0);
  endtask

  task automatic compare_irq(input string tag);
    int bad;
    bad = -1;
    for (int v = 0; v < N; v++) if (irq_cnt[v] != exp_irq[v] && bad < 0) bad = v;
    if (bad >= 0)
      check(1'b0, $sformatf("%s irq count v%0d", tag, bad), irq_cnt[bad], exp_irq[bad]);
    else check(1'b1, tag, 0, 0);
  endtask

  task automatic raise_v(input logic [N-1:0] m);
    @(negedge clk); raise = m;
    @(negedge clk); raise = '0;
  endtask

  task automatic wait_done(input int target, input string tag);
    int t;
    t = 0;
    while ((clr_n < target || busy) && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    check(t < 5000, {tag, " completion"}, t, 0);
  endtask

  task automatic write_en(input logic [N-1:0] d);
    @(negedge clk); en_wr = 1'b1; en_wdata = d;
    @(negedge clk); en_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr + 1, nchk + 1);
    $finish;
  end

  initial begin
    int n0, b0;
    logic [N-1:0] m;
    void'($urandom(32'd4711));
    clk = 1'b0; rst_n = 1'b0; en_wr = 1'b0; en_wdata = '0; raise = '0;
    hw_en = 1'b0; hw_addr = '0; hw_data = '0; stall = 1'b0;
    nchk = 0; nerr = 0;
    for (int a = 0; a < 4096; a++) begin mem[a] = 8'h00; exp_m[a] = 8'h00; end
    for (int v = 0; v < N; v++) exp_irq[v] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    check(!busy && !mem_req && !cpu_irq && !flag_clr, "R13 reset outputs",
          {busy, mem_req, cpu_irq, flag_clr}, 0);
    check(en_q == '0, "R13 en_q after reset", en_q, 0);

    // R10 unassigned bits read zero
    write_en(8'hFF);
    check(en_q == ASG, "R10 en_q masks unassigned", en_q, ASG);
    repeat (3) @(negedge clk);

    // R1 R2 R3 R4 R5: byte item with both advances, count 2
    setup(0, 3'b110, 16'h0400, 16'h0800, 16'd2);
    raise_v(8'h01);
    wait_done(clr_n + 1, "R1 v0 first");
    model_xfer(0);
    compare_mem("R2 R3 R4 R5 byte advance");
    compare_irq("R6 no irq at nonzero count");
    raise_v(8'h01);
    wait_done(clr_n + 1, "R1 v0 second");
    model_xfer(0);
    compare_mem("R3 R4 second byte");
    compare_irq("R6 irq at zero count");
    check(clr_log[0] == 0 && clr_log[1] == 0 && clr_n == 2, "R7 clear strobes v0",
          clr_n, 2);
    check(en_q == ASG, "R8 enable untouched after completion", en_q, ASG);

    // R2 R3 R4: word item, no advance, count 1
    setup(1, 3'b001, 16'h0480, 16'h0880, 16'd1);
    raise_v(8'h02);
    wait_done(clr_n + 1, "R2 v1");
    model_xfer(1);
    compare_mem("R2 R3 R4 word fixed addresses");
    compare_irq("R6 irq word count 1");

    // R9 disabled request ignored, then enable timing
    write_en(8'h00);
    repeat (3) @(negedge clk);
    setup(2, 3'b111, 16'h0500, 16'h0900, 16'd3);
    b0 = busy_cyc;
    raise_v(8'h04);
    repeat (12) @(negedge clk);
    check(busy_cyc == b0 && irq_req[2], "R9 disabled request not served", busy_cyc, b0);
    en_wr = 1'b1; en_wdata = ASG;
    @(posedge clk);
    @(negedge clk); en_wr = 1'b0;
    check(!busy, "R9 busy after write edge", busy, 0);
    @(negedge clk); check(!busy, "R9 busy after edge +1", busy, 0);
    @(negedge clk); check(!busy, "R9 busy after edge +2", busy, 0);
    @(negedge clk); check(!busy, "R9 busy after edge +3", busy, 0);
    @(negedge clk); check(busy,  "R9 busy after edge +4", busy, 1);
    wait_done(clr_n, "R9 v2");
    model_xfer(2);
    compare_mem("R9 transfer after enable");

    // R10 unassigned vector never served
    setup(3, 3'b111, 16'h0580, 16'h0980, 16'd1);
    b0 = busy_cyc; n0 = clr_n;
    raise_v(8'h08);
    repeat (20) @(negedge clk);
    check(busy_cyc == b0, "R10 no busy for unassigned", busy_cyc, b0);
    check(clr_n == n0, "R10 no clear for unassigned", clr_n, n0);
    compare_mem("R10 memory untouched");

    // R11 held requests, lowest vector first
    setup(5, 3'b010, 16'h0600, 16'h0A00, 16'd2);
    setup(7, 3'b101, 16'h0680, 16'h0A80, 16'd1);
    setup(2, 3'b001, 16'h0500, 16'h0900, 16'd1);
    n0 = clr_n;
    raise_v(8'h20);
    while (!busy) @(negedge clk);
    raise_v(8'h84);
    wait_done(n0 + 3, "R11 queue");
    check(clr_log[n0] == 5 && clr_log[n0 + 1] == 2 && clr_log[n0 + 2] == 7,
          "R11 service order", clr_log[n0 + 1], 2);
    model_xfer(5); model_xfer(2); model_xfer(7);
    compare_mem("R11 queued transfers");
    compare_irq("R6 R11 queued irqs");

    // random rounds with memory stalls
    stall = 1'b1;
    for (int r = 0; r < 20; r++) begin
      m = 8'($urandom) & ASG;
      if (m == '0) m = 8'h01;
      for (int v = 0; v < N; v++)
        if (m[v]) setup(v, 3'($urandom), 16'h0400 + 16'(128 * v) + 16'(2 * ($urandom % 8)),
                        16'h0800 + 16'(128 * v) + 16'(2 * ($urandom % 8)),
                        16'd1 + 16'($urandom % 3));
      n0 = clr_n;
      raise_v(m);
      wait_done(n0 + $countones(m), "R12 random round");
      for (int v = 0; v < N; v++) if (m[v]) model_xfer(v);
      compare_mem($sformatf("R2 R5 random round %0d", r));
      compare_irq($sformatf("R6 random round %0d", r));
      check(!busy && !mem_req, "R12 idle after round", {busy, mem_req}, 0);
    end
    check(en_q == ASG, "R8 enable untouched at end", en_q, ASG);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule